// File: doc/BRIEF.md
# Multi-Format Audio Serial Receiver

This block takes stereo PCM audio from a three-wire serial link: a bit clock, a word clock that marks left and right half-frames, and a serial data line. All three lines are sampled by a fast system clock. The block finds the bit-clock rising edges itself and collects one data bit on each of them. A 3-bit format select chooses one of five framings. Two of them fix the word start relative to the word-clock transition: the left-justified framing and the one-bit-delayed framing common in audio codecs. The other three are right-justified, so the word ends on the last bit period before the next word-clock transition.

For every channel word it receives, the block emits a 24-bit two's-complement sample with a one-cycle valid strobe and a tag that tells left from right. Shorter right-justified words of 16 or 20 bits are placed in the top bits of the 24-bit output, and the bits below them are zero. The bit and word clocks must be much slower than the system clock. The word clock should change on bit-clock falling edges, because a word-clock change that lands on a rising edge is not a valid condition.

Top module: `pcm_serial_rx`

## Requirements
- R1: With format select 010 (left-justified, 24 bits), the 24 bits on the first 24 bit-clock rising edges after a word-clock transition form the sample, MSB first. A source with a 16-bit or 20-bit word that sends zeros in the remaining low bits is received unchanged.
- R2: With format select 011 (one-bit-delayed framing), the bit on the first rising edge after a word-clock transition is skipped, and the next 24 bits form the sample, MSB first.
- R3: With format select 000, 001 or 100, the last 16, 20 or 24 bits before a word-clock transition form the word, and earlier bits in that half-frame are ignored. 16-bit and 20-bit words are output in the top bits of the sample, with zeros below them.
- R4: `right_o` is 0 for the left channel. In the justified framings (000, 001, 010, 100) the left channel is word clock high. In framing 011 the left channel is word clock low.
- R5: `valid_o` is high for exactly one system clock per received word. The pulse comes three system clocks after the bit-clock rising edge that completes the word, counted from the first system clock edge that sees the bit clock high. For right-justified framings, the completing edge is the first rising edge after the word-clock transition.
- R6: A half-frame that has fewer bit periods than the selected framing needs produces no sample. Fewer than 24 bits is too short for 010 and 011, and fewer than the word width is too short for the right-justified framings. A 16-bit right-justified word in a 16-bit half-frame (32 bit clocks per sample period) is accepted.
- R7: Format select codes 101, 110 and 111 produce no samples.
- R8: After reset, `valid_o`, `sample_o` and `right_o` are 0. No sample is produced from bits received before the first word-clock transition.
- R9: With framing 011 and exactly 24 bit periods per half-frame, the word's last bit falls on the first rising edge of the following half-frame. That edge completes the word, and the word keeps the tag of the half-frame it started in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock, asynchronous to clk |
| wclk_i | input | 1 | Word clock marking left/right half-frames |
| sdata_i | input | 1 | Serial audio data, MSB first |
| fmt_sel_i | input | 3 | Framing select (000, 001, 010, 011, 100) |
| sample_o | output | 24 | Received two's-complement sample, left-aligned |
| valid_o | output | 1 | One-cycle strobe marking a new sample |
| right_o | output | 1 | Channel tag of the sample: 1 = right |

## Verification
On every cycle, the assertions check that each valid strobe lasts one clock and follows a detected bit-clock rising edge. They also check that no strobe appears while the receiver has not yet seen a word-clock transition, or while the format code is unsupported. Only the bench scenarios can show where each framing places its word, the left-alignment of short words, the channel tags, the dropping of short half-frames, and the spill of a delayed-framing word into the next half-frame. For those, the bench builds serial streams from the framing rules and compares every strobe, sample and tag against the expected cycle.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

   localparam int WORD_W = 24;

   typedef enum logic [1:0] {
      FR_NONE,
      FR_LEFT,
      FR_DELAY1,
      FR_RIGHT
   } frame_e;

   typedef struct packed {
      frame_e     kind;
      logic [4:0] width;
   } fmt_t;

   function automatic fmt_t decode_fmt(input logic [2:0] sel);
      fmt_t f;
      unique case (sel)
         3'b000:  f = '{kind: FR_RIGHT,  width: 5'd16};
         3'b001:  f = '{kind: FR_RIGHT,  width: 5'd20};
         3'b010:  f = '{kind: FR_LEFT,   width: 5'd24};
         3'b011:  f = '{kind: FR_DELAY1, width: 5'd24};
         3'b100:  f = '{kind: FR_RIGHT,  width: 5'd24};
         default: f = '{kind: FR_NONE,   width: 5'd0};
      endcase
      return f;
   endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_i,
   input  logic wclk_i,
   input  logic sdata_i,
   output logic rise_o,
   output logic wlv_o,
   output logic dat_o
);

   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("pcm_rx_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][2:0] chain_q;
   logic                   bclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         bclk_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], {bclk_i, wclk_i, sdata_i}};
         bclk_q  <= chain_q[LAST][2];
      end
   end

   assign rise_o = chain_q[LAST][2] & ~bclk_q;
   assign wlv_o  = chain_q[LAST][1];
   assign dat_o  = chain_q[LAST][0];

   // R5: a detected rising edge lasts a single system clock
   a_r5_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/pcm_rx_capture.sv
module pcm_rx_capture
   import pcm_rx_pkg::*;
#(
   parameter int CNT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic              wlv_i,
   input  logic              dat_i,
   input  logic [2:0]        fmt_sel_i,
   output logic [WORD_W-1:0] sample_o,
   output logic              valid_o,
   output logic              right_o
);

   localparam logic [CNT_W-1:0] IDX_MAX = '1;
   localparam int               N_RJ    = 3;
   localparam int               RJ_W [N_RJ] = '{16, 20, 24};

   if (CNT_W < 5) begin : g_bad_cnt
      $error("pcm_rx_capture: CNT_W must be at least 5");
   end

   logic              seen_q, armed_q, wl_prev_q;
   logic [CNT_W-1:0]  idx_q, cur_idx;
   logic [WORD_W-1:0] sh_q, word_in, word;
   logic [WORD_W-1:0] rj_word [N_RJ];
   logic              edge_w, emit, rgt;
   int                prev_len;
   fmt_t              f;

   // right-justified words, left-aligned into the output width
   for (genvar k = 0; k < N_RJ; k++) begin : g_rj
      assign rj_word[k] = sh_q << (WORD_W - RJ_W[k]);
   end

   assign f        = decode_fmt(fmt_sel_i);
   assign edge_w   = seen_q && (wlv_i != wl_prev_q);
   assign word_in  = {sh_q[WORD_W-2:0], dat_i};
   assign prev_len = int'(idx_q) + 1;

   always_comb begin
      if (edge_w)              cur_idx = '0;
      else if (idx_q == IDX_MAX) cur_idx = IDX_MAX;
      else                     cur_idx = idx_q + 1'b1;
   end

   always_comb begin
      emit = 1'b0;
      word = word_in;
      rgt  = 1'b0;
      unique case (f.kind)
         FR_LEFT: begin
            emit = armed_q && !edge_w && (int'(cur_idx) == WORD_W - 1);
            rgt  = ~wlv_i;
         end
         FR_DELAY1: begin
            if (armed_q && !edge_w && (int'(cur_idx) == WORD_W)) begin
               emit = 1'b1;
               rgt  = wlv_i;
            end else if (armed_q && edge_w && (int'(idx_q) == WORD_W - 1)) begin
               emit = 1'b1;
               rgt  = wl_prev_q;
            end
         end
         FR_RIGHT: begin
            emit = armed_q && edge_w && (prev_len >= int'(f.width));
            rgt  = ~wl_prev_q;
            unique case (f.width)
               5'd16:   word = rj_word[0];
               5'd20:   word = rj_word[1];
               default: word = rj_word[2];
            endcase
         end
         default: emit = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_q    <= 1'b0;
         armed_q   <= 1'b0;
         wl_prev_q <= 1'b0;
         idx_q     <= '0;
         sh_q      <= '0;
         sample_o  <= '0;
         valid_o   <= 1'b0;
         right_o   <= 1'b0;
      end else begin
         valid_o <= rise_i && emit;
         if (rise_i) begin
            seen_q    <= 1'b1;
            wl_prev_q <= wlv_i;
            idx_q     <= cur_idx;
            sh_q      <= word_in;
            armed_q   <= armed_q | edge_w;
            if (emit) begin
               sample_o <= word;
               right_o  <= rgt;
            end
         end
      end
   end

   // R8: nothing leaves before the first word-clock transition
   a_r8_silent_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
      !armed_q |=> !valid_o);

   // R7: unsupported format codes never yield a sample
   a_r7_bad_fmt_silent: assert property (@(posedge clk) disable iff (!rst_n)
      (fmt_sel_i inside {3'b101, 3'b110, 3'b111}) |=> !valid_o);

   // R5: a strobe is one clock wide
   a_r5_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

endmodule

// File: rtl/pcm_serial_rx.sv
module pcm_serial_rx
   import pcm_rx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk_i,
   input  logic              wclk_i,
   input  logic              sdata_i,
   input  logic [2:0]        fmt_sel_i,
   output logic [WORD_W-1:0] sample_o,
   output logic              valid_o,
   output logic              right_o
);

   logic rise_w, wlv_w, dat_w;

   pcm_rx_sync #(
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .bclk_i  (bclk_i),
      .wclk_i  (wclk_i),
      .sdata_i (sdata_i),
      .rise_o  (rise_w),
      .wlv_o   (wlv_w),
      .dat_o   (dat_w)
   );

   pcm_rx_capture #(
      .CNT_W (CNT_W)
   ) i_capture (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise_i    (rise_w),
      .wlv_i     (wlv_w),
      .dat_i     (dat_w),
      .fmt_sel_i (fmt_sel_i),
      .sample_o  (sample_o),
      .valid_o   (valid_o),
      .right_o   (right_o)
   );

   // R5: every strobe is caused by a bit-clock rising edge one clock earlier
   a_r5_valid_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> $past(rise_w));

endmodule

// File: tb/test_pcm_serial_rx.sv
`timescale 1ns/1ps
module test_pcm_serial_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b0, wclk = 1'b0, sdata = 1'b0;
   logic [2:0]  fmt = 3'b000;
   logic [23:0] sample;
   logic        valid, right;

   always #2.5 clk = ~clk;

   pcm_serial_rx i_pcm_serial_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_i    (bclk),
      .wclk_i    (wclk),
      .sdata_i   (sdata),
      .fmt_sel_i (fmt),
      .sample_o  (sample),
      .valid_o   (valid),
      .right_o   (right)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int    n_chk = 0, n_fail = 0;
   string cur_req = "R8";

   int          q_cyc[$];
   logic [23:0] q_smp[$];
   bit          q_rgt[$];
   int          p_pos[$];
   logic [23:0] p_smp[$];
   bit          p_rgt[$];

   bit          s_bit [1024];
   bit          s_lv  [1024];
   int          s_len;
   logic [23:0] w_list [8];
   int unsigned lcg = 32'h1234_5678;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   // per-clock comparison against the expected event queue
   always @(negedge clk) begin
      if (rst_n) begin
         if (valid) begin
            if (q_cyc.size() == 0) begin
               check(1'b0, cur_req, "unexpected valid", sample, 0);
            end else begin
               check(q_cyc[0] == cyc, "R5", "strobe cycle", cyc, q_cyc[0]);
               check(q_smp[0] == sample, cur_req, "sample", sample, q_smp[0]);
               check(q_rgt[0] == right, "R4", "channel tag", right, q_rgt[0]);
               void'(q_cyc.pop_front());
               void'(q_smp.pop_front());
               void'(q_rgt.pop_front());
            end
         end else if (q_cyc.size() > 0 && q_cyc[0] < cyc) begin
            check(1'b0, "R5", "missing strobe at cycle", cyc, q_cyc[0]);
            void'(q_cyc.pop_front());
            void'(q_smp.pop_front());
            void'(q_rgt.pop_front());
         end
      end
   end

   always @(posedge clk) begin
      if (cyc == 100000) begin
         n_chk++;
         n_fail++;
         $display("FAIL all watchdog expired: actual=%0d expected=<100000", cyc);
         report();
      end
   end

   task automatic make_words(input bit zero_low);
      for (int i = 0; i < 8; i++) begin
         lcg = lcg * 32'd1103515245 + 32'd12345;
         w_list[i] = lcg[31:8] ^ {lcg[7:0], 16'h0};
         if (zero_low) w_list[i][7:0] = 8'h00;
      end
      w_list[0] = 24'h7FFFFF;
      w_list[1] = 24'h800001;
   endtask

   // build the serial stream and the list of expected samples from the framing rules
   task automatic build(input int f, input int b, input int nh, input bit lv0);
      int nw, start;
      bit lv;
      logic [23:0] w;
      nw = (f == 0) ? 16 : (f == 1) ? 20 : 24;
      s_len = 3 + nh * b + 2;
      p_pos.delete(); p_smp.delete(); p_rgt.delete();
      for (int p = 0; p < s_len; p++) begin
         s_bit[p] = ((p * 37) >> 2) % 2 == 1;
         s_lv[p]  = ~lv0;
      end
      for (int h = 0; h < nh; h++)
         for (int p = 3 + h * b; p < 3 + (h + 1) * b; p++) s_lv[p] = lv0 ^ h[0];
      for (int p = 3 + nh * b; p < s_len; p++) s_lv[p] = lv0 ^ nh[0];
      for (int h = 0; h < nh; h++) begin
         start = 3 + h * b;
         lv    = lv0 ^ h[0];
         w     = w_list[h] & ((24'd1 << nw) - 24'd1);
         if (nw == 24) w = w_list[h];
         if (f == 2 && b >= 24) begin
            for (int i = 0; i < 24; i++) s_bit[start + i] = w[23 - i];
            p_pos.push_back(start + 23);
         end else if (f == 3 && b >= 24) begin
            for (int i = 0; i < 24; i++) s_bit[start + 1 + i] = w[23 - i];
            p_pos.push_back(start + 24);
         end else if ((f == 0 || f == 1 || f == 4) && b >= nw) begin
            for (int i = 0; i < nw; i++) s_bit[start + b - nw + i] = w[nw - 1 - i];
            p_pos.push_back(start + b);
         end else begin
            continue;
         end
         p_smp.push_back(w << (24 - nw));
         p_rgt.push_back((f == 3) ? lv : ~lv);
      end
   endtask

   task automatic run(input string req, input int f, input int b, input int nh,
                      input bit lv0, input bit zero_low);
      cur_req = req;
      rst_n = 1'b0; bclk = 1'b0; wclk = 1'b0; sdata = 1'b0;
      fmt = 3'(f);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(valid == 1'b0 && sample == 24'h0 && right == 1'b0, "R8", "reset outputs",
            {valid, right, sample}, 0);
      make_words(zero_low);
      build(f, b, nh, lv0);
      for (int p = 0; p < s_len; p++) begin
         bclk = 1'b0; sdata = s_bit[p]; wclk = s_lv[p];
         repeat (4) @(negedge clk);
         bclk = 1'b1;
         if (p_pos.size() > 0 && p_pos[0] == p) begin
            q_cyc.push_back(cyc + 3);
            q_smp.push_back(p_smp[0]);
            q_rgt.push_back(p_rgt[0]);
            void'(p_pos.pop_front());
            void'(p_smp.pop_front());
            void'(p_rgt.pop_front());
         end
         repeat (4) @(negedge clk);
      end
      bclk = 1'b0;
      repeat (40) @(negedge clk);
      check(q_cyc.size() == 0 && p_pos.size() == 0, req, "words left undelivered",
            q_cyc.size() + p_pos.size(), 0);
   endtask

   initial begin
      run("R1", 2, 32, 4, 1'b1, 1'b0);
      run("R1", 2, 32, 4, 1'b0, 1'b1);   // 16-bit source, zero low bits
      run("R1", 2, 24, 4, 1'b1, 1'b0);   // 48 bit clocks per sample
      run("R2", 3, 32, 4, 1'b0, 1'b0);
      run("R3", 0, 32, 4, 1'b1, 1'b0);
      run("R3", 1, 32, 4, 1'b0, 1'b0);
      run("R3", 4, 32, 4, 1'b1, 1'b0);
      run("R6", 0, 16, 4, 1'b1, 1'b0);   // 32 bit clocks per sample accepted
      run("R6", 2, 16, 4, 1'b1, 1'b0);   // too short: dropped
      run("R6", 4, 20, 4, 1'b0, 1'b0);   // too short: dropped
      run("R6", 3, 20, 4, 1'b0, 1'b0);   // too short: dropped
      run("R9", 3, 24, 4, 1'b1, 1'b0);
      run("R7", 5, 32, 3, 1'b1, 1'b0);
      run("R7", 7, 32, 3, 1'b0, 1'b0);
      report();
   end

endmodule